// File: doc/BRIEF.md
# ADC Sample Averager

This block takes one averaged reading from an analog-to-digital converter that lives inside a PHY and is reached only through a register port. A one-cycle start pulse launches a measurement. The block first writes a caller-supplied mode word to the tuning-control register, which selects what the converter measures. It then reads the converter's output register over and over. Every returned word has a flag bit that says whether the sample is fresh. Only flagged words count toward the totals.

A measurement has two phases. The warm-up phase throws away the first two valid samples. The accumulate phase then adds up the 10-bit values of the next 80 valid samples. Each phase has its own limit on read attempts, so a converter that stops producing valid words cannot hang the block. When the sum is complete, a bit-serial divider computes sum × 1000 / 80, truncated toward zero. The block then reports the result with a one-cycle done pulse and a sticky timeout flag.

The register request channel uses valid/ready. Once the block raises a request, it holds `req_valid_o`, the address, the write flag and the write data unchanged until `req_ready_i` is seen high at a clock edge. Writes get no response. Each accepted read is followed by exactly one response beat. The block raises `rsp_ready_o` only while one read is outstanding, and it issues no new request until that response has been taken. The responder may stall requests and delay responses for any number of cycles.

Top module: `adcavg_top`

## Requirements
- R1: A start pulse seen while idle causes exactly one write request, to address 0x0009 with the mode word sampled at start. This write comes before any read. A start pulse seen while a measurement is running has no effect.
- R2: Every read request targets address 0x000A.
- R3: In a response word, bit 10 is the valid flag and bits 9:0 are the sample. Words with bit 10 clear, and bits 15:11 of every word, do not contribute to the sum.
- R4: The warm-up phase ends after two valid words. Those two values are never added to the sum.
- R5: The accumulate phase ends after 80 valid words. No further read is issued after that.
- R6: Each phase starts a fresh attempt count. If a phase has not reached its target after 101 reads, it ends after the 101st read.
- R7: If either phase ends on its attempt limit, `timeout_o` is set. It stays set after done, and the next accepted start clears it.
- R8: `result_o` equals floor(sum × 1000 / 80). A full-scale sum of 80 × 1023 does not overflow. `result_o` changes only in the cycle where `done_o` is high.
- R9: `done_o` is high for exactly one cycle per measurement.
- R10: A pending request holds its valid, address, write flag and data stable until it is accepted. `rsp_ready_o` is high only when no request is pending.
- R11: During and right after reset, no request is pending, `rsp_ready_o`, `done_o` and `timeout_o` are low, and `result_o` is zero. A reset in the middle of a measurement returns the block to this state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches a measurement when the block is idle |
| mode_word_i | input | 16 | Word written to the tuning-control register |
| req_valid_o | output | 1 | Register request pending |
| req_ready_i | input | 1 | Responder accepts the request |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 16 | Register address |
| req_wdata_o | output | 16 | Write data |
| rsp_valid_i | input | 1 | Read response beat present |
| rsp_ready_o | output | 1 | Block is waiting for a read response |
| rsp_data_i | input | 16 | Read data: bit 10 valid flag, bits 9:0 sample |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Sticky: a phase hit its attempt limit |
| result_o | output | 27 | Scaled average, sum × 1000 / 80 |

## Verification
The bench drives streams in which invalid words appear at fixed intervals, so a design that counted unflagged words would stop early with the wrong sum. The bench also varies the sample values from full scale to ramps, which exposes a design that adds the warm-up pair or loses carries in a narrow accumulator. Some patterns are sparse enough that the 101-read budget runs out in the first phase, others only in the second. A design that shared one attempt counter across both phases, or that stopped one read early or late, would report the wrong read count or timeout flag. Request stalls and response delays catch a design that drops or changes a request under back-pressure. A second start during a run, a reset mid-measurement, and a clean run after a timed-out one show whether the flag is cleared and whether busy starts are ignored.

// File: rtl/adcavg_pkg.sv
`timescale 1ns/1ps
package adcavg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_DIV
  } adcavg_state_t;

  typedef enum logic {
    PH_WARM,
    PH_ACC
  } adcavg_phase_t;

endpackage

// File: rtl/adcavg_phase_ctr.sv
`timescale 1ns/1ps
module adcavg_phase_ctr #(
  parameter int CNT_W = 7,
  parameter int LIMIT = 100,
  localparam int ATT_W = $clog2(LIMIT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic             flag_i,
  input  logic [CNT_W-1:0] target_i,
  output logic             fin_o,
  output logic             short_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [ATT_W-1:0] att_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [ATT_W-1:0] att_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(flag_i);
  assign att_nxt = att_q + ATT_W'(1);

  // The outcome of the word being consumed now: the phase is over when the
  // target is met, or when this read pushes the attempt count past the limit.
  assign short_o = (cnt_nxt != target_i);
  assign fin_o   = !short_o || (att_nxt > ATT_W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      att_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      att_q <= '0;
    end else if (hit_i) begin
      cnt_q <= cnt_nxt;
      att_q <= att_nxt;
    end
  end

endmodule

// File: rtl/adcavg_divider.sv
`timescale 1ns/1ps
module adcavg_divider #(
  parameter int DVD_W   = 27,
  parameter int DIVISOR = 80,
  localparam int DVS_W  = $clog2(DIVISOR + 1),
  localparam int CW     = $clog2(DVD_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  output logic             done_o,
  output logic [DVD_W-1:0] quot_o
);

  localparam logic [DVS_W:0] DIV_V = (DVS_W + 1)'(DIVISOR);

  logic             busy_q;
  logic [CW-1:0]    cnt_q;
  logic [DVS_W-1:0] rem_q;
  logic [DVD_W-1:0] work_q;
  logic [DVD_W-1:0] res_q;
  logic             done_q;

  logic [DVS_W:0]   shifted;
  logic [DVS_W:0]   diff;
  logic             ge;
  logic [DVS_W-1:0] rem_n;
  logic [DVD_W-1:0] work_n;

  // One restoring step per cycle, most significant dividend bit first.
  assign shifted = {rem_q, work_q[DVD_W-1]};
  assign ge      = (shifted >= DIV_V);
  assign diff    = shifted - DIV_V;
  assign rem_n   = ge ? diff[DVS_W-1:0] : shifted[DVS_W-1:0];
  assign work_n  = {work_q[DVD_W-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      work_q <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(DVD_W);
        rem_q  <= '0;
        work_q <= dividend_i;
      end else if (busy_q) begin
        rem_q  <= rem_n;
        work_q <= work_n;
        cnt_q  <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          res_q  <= work_n;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = res_q;

endmodule

// File: rtl/adcavg_top.sv
`timescale 1ns/1ps
module adcavg_top
  import adcavg_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int SAMPLE_W      = 10,
  parameter int FLAG_BIT      = 10,
  parameter int WARMUP        = 2,
  parameter int NSAMP         = 80,
  parameter int ATTEMPT_LIMIT = 100,
  parameter int SCALE         = 1000,
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(9),
  parameter logic [ADDR_W-1:0] ADC_ADDR  = ADDR_W'(10),
  localparam int ACC_W = $clog2(NSAMP * ((1 << SAMPLE_W) - 1) + 1),
  localparam int RES_W = $clog2(NSAMP * ((1 << SAMPLE_W) - 1) * SCALE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] mode_word_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic              req_write_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [DATA_W-1:0] req_wdata_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic [RES_W-1:0]  result_o
);

  localparam int MAXT  = (WARMUP > NSAMP) ? WARMUP : NSAMP;
  localparam int CNT_W = $clog2(MAXT + 1);

  adcavg_state_t     state_q;
  adcavg_phase_t     phase_q;
  logic [DATA_W-1:0] mode_q;
  logic [ACC_W-1:0]  acc_q;
  logic              to_q;

  logic                rsp_hit;
  logic                word_ok;
  logic [SAMPLE_W-1:0] word_val;
  logic [ACC_W-1:0]    acc_nxt;
  logic [CNT_W-1:0]    target;
  logic                fin;
  logic                short_cnt;
  logic                phase_end;
  logic                ctr_clr;
  logic                div_start;
  logic [RES_W-1:0]    dividend;
  logic                div_done;
  logic                unused_hi;

  assign rsp_hit   = (state_q == ST_RD_WAIT) && rsp_valid_i;
  assign word_ok   = rsp_data_i[FLAG_BIT];
  assign word_val  = rsp_data_i[SAMPLE_W-1:0];
  assign unused_hi = ^rsp_data_i[DATA_W-1:FLAG_BIT+1];

  assign acc_nxt = acc_q + ((phase_q == PH_ACC && word_ok) ? ACC_W'(word_val) : '0);
  assign target  = (phase_q == PH_WARM) ? CNT_W'(WARMUP) : CNT_W'(NSAMP);

  assign phase_end = rsp_hit && fin;
  assign ctr_clr   = ((state_q == ST_IDLE) && start_i) ||
                     (phase_end && phase_q == PH_WARM);
  assign div_start = phase_end && (phase_q == PH_ACC);
  assign dividend  = RES_W'(acc_nxt) * RES_W'(SCALE);

  adcavg_phase_ctr #(
    .CNT_W (CNT_W),
    .LIMIT (ATTEMPT_LIMIT)
  ) ctr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (ctr_clr),
    .hit_i    (rsp_hit),
    .flag_i   (word_ok),
    .target_i (target),
    .fin_o    (fin),
    .short_o  (short_cnt)
  );

  adcavg_divider #(
    .DVD_W   (RES_W),
    .DIVISOR (NSAMP)
  ) div_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (dividend),
    .done_o     (div_done),
    .quot_o     (result_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_WARM;
      mode_q  <= '0;
      acc_q   <= '0;
      to_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q  <= mode_word_i;
            acc_q   <= '0;
            to_q    <= 1'b0;
            phase_q <= PH_WARM;
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (req_ready_i) state_q <= ST_RD_REQ;
        end
        ST_RD_REQ: begin
          if (req_ready_i) state_q <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          if (rsp_valid_i) begin
            acc_q <= acc_nxt;
            if (fin) begin
              if (short_cnt) to_q <= 1'b1;
              if (phase_q == PH_WARM) begin
                phase_q <= PH_ACC;
                state_q <= ST_RD_REQ;
              end else begin
                state_q <= ST_DIV;
              end
            end else begin
              state_q <= ST_RD_REQ;
            end
          end
        end
        ST_DIV: begin
          if (div_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_WRITE) || (state_q == ST_RD_REQ);
  assign req_write_o = (state_q == ST_WRITE);
  assign req_addr_o  = (state_q == ST_WRITE) ? MODE_ADDR : ADC_ADDR;
  assign req_wdata_o = (state_q == ST_WRITE) ? mode_q : '0;
  assign rsp_ready_o = (state_q == ST_RD_WAIT);
  assign done_o      = div_done;
  assign timeout_o   = to_q;

endmodule

// File: rtl/adcavg_chk.sv
`timescale 1ns/1ps
module adcavg_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int RES_W  = 27,
  parameter logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(9),
  parameter logic [ADDR_W-1:0] ADC_ADDR  = ADDR_W'(10)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_write_o,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic [DATA_W-1:0] req_wdata_o,
  input logic              rsp_ready_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic [RES_W-1:0]  result_o
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_write_o) && $stable(req_wdata_o)));

  // R10
  rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready_o |-> !req_valid_o);

  // R1
  write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && req_write_o) |-> (req_addr_o == MODE_ADDR));

  // R2
  read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_write_o) |-> (req_addr_o == ADC_ADDR));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!req_valid_o && !rsp_ready_o));

  // R7
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_o) |-> $past(start_i));

  // R8
  result_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);

endmodule

bind adcavg_top adcavg_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .RES_W     (RES_W),
  .MODE_ADDR (MODE_ADDR),
  .ADC_ADDR  (ADC_ADDR)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_write_o (req_write_o),
  .req_addr_o  (req_addr_o),
  .req_wdata_o (req_wdata_o),
  .rsp_ready_o (rsp_ready_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .result_o    (result_o)
);

// File: tb/adcavg_top_tb_top.sv
`timescale 1ns/1ps
module adcavg_top_tb_top;

  localparam int NV = 8;
  localparam int V_BASE [NV] = '{0, 1023, 3, 5, 100, 511, 1, 999};
  localparam int V_STEP [NV] = '{0, 0, 7, 13, 1, 0, 1, 333};
  localparam int V_INV  [NV] = '{0, 0, 0, 5, 3, 1, 6, 2};
  localparam int V_STALL[NV] = '{0, 1, 0, 2, 0, 1, 0, 3};
  localparam int V_MODE [NV] = '{16'h0001, 16'h0013, 16'h5A5A, 16'h1234,
                                 16'h0F0F, 16'hFFFF, 16'h0002, 16'h8001};
  localparam int V_TO   [NV] = '{0, 0, 0, 0, 1, 1, 0, 1};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] mode_word_i;
  logic        req_valid_o;
  logic        req_ready_i;
  logic        req_write_o;
  logic [15:0] req_addr_o;
  logic [15:0] req_wdata_o;
  logic        rsp_valid_i;
  logic        rsp_ready_o;
  logic [15:0] rsp_data_i;
  logic        done_o;
  logic        timeout_o;
  logic [26:0] result_o;

  always #10 clk = ~clk;

  adcavg_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_word_i (mode_word_i),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_write_o (req_write_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ready_o (rsp_ready_o),
    .rsp_data_i  (rsp_data_i),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .result_o    (result_o)
  );

  int n_chk = 0;
  int n_err = 0;

  // Responder configuration and observations.
  int cur_base, cur_step, cur_inv, cur_stall, cur_mode;
  int k, n_wr, n_rd, bad_order, bad_wr, bad_addr;
  int cyc = 0;
  bit hs_last, rsp_last, pend;
  int rdly;
  bit cap_write;
  logic [15:0] cap_addr, cap_data;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit gen_ok(input int idx, input int inv);
    return !(inv != 0 && (idx % inv) == inv - 1);
  endfunction

  function automatic int gen_val(input int idx, input int base, input int step);
    return (base + idx * step) % 1024;
  endfunction

  // Independent model of the two phases.
  task automatic model(input int base, input int step, input int inv,
                       output int sum, output bit to, output int reads);
    int idx = 0;
    sum = 0;
    to = 0;
    for (int ph = 0; ph < 2; ph++) begin
      int got = 0;
      int att = 0;
      int tgt = (ph == 0) ? 2 : 80;
      while (1) begin
        bit v = gen_ok(idx, inv);
        if (v) begin
          got++;
          if (ph == 1) sum += gen_val(idx, base, step);
        end
        idx++;
        att++;
        if (got == tgt) break;
        if (att > 100) begin
          to = 1;
          break;
        end
      end
    end
    reads = idx;
  endtask

  // Register responder, driven away from the active edge.
  initial begin
    hs_last = 0; rsp_last = 0; pend = 0; rdly = 0;
    req_ready_i = 0; rsp_valid_i = 0; rsp_data_i = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        hs_last = 0; rsp_last = 0; pend = 0;
        rsp_valid_i = 0; req_ready_i = 0;
      end else begin
        if (hs_last) begin
          if (cap_write) begin
            n_wr++;
            if (n_rd != 0) bad_order++;
            if (cap_addr != 16'h0009 || cap_data != cur_mode[15:0]) bad_wr++;
          end else begin
            n_rd++;
            if (n_wr == 0) bad_order++;
            if (cap_addr != 16'h000A) bad_addr++;
            pend = 1;
            rdly = cur_stall;
          end
        end
        if (rsp_last) rsp_valid_i = 0;
        if (pend && !rsp_valid_i) begin
          if (rdly == 0) begin
            rsp_valid_i = 1;
            rsp_data_i = {5'b10101, gen_ok(k, cur_inv), 10'(gen_val(k, cur_base, cur_step))};
            k++;
            pend = 0;
          end else begin
            rdly--;
          end
        end
        req_ready_i = (cur_stall == 0) || ((cyc % (cur_stall + 1)) == 0);
        hs_last   = req_valid_o && req_ready_i;
        cap_write = req_write_o;
        cap_addr  = req_addr_o;
        cap_data  = req_wdata_o;
        rsp_last  = rsp_valid_i && rsp_ready_o;
      end
    end
  end

  task automatic run_measure(input int base, input int step, input int inv, input int stall,
                             input int mode, input int exp_to, input int poke);
    int sum, reads, cycles;
    bit to;
    cur_base = base; cur_step = step; cur_inv = inv; cur_stall = stall; cur_mode = mode;
    k = 0; n_wr = 0; n_rd = 0; bad_order = 0; bad_wr = 0; bad_addr = 0;
    @(negedge clk);
    start_i = 1; mode_word_i = mode[15:0];
    @(negedge clk);
    start_i = 0; mode_word_i = 16'hDEAD;
    cycles = 0;
    while (!done_o && cycles < 6000) begin
      if (poke != 0 && cycles == poke) start_i = 1;
      else start_i = 0;
      @(negedge clk);
      cycles++;
    end
    start_i = 0;
    chk(done_o == 1'b1, "R9 done seen before limit", done_o, 1);
    model(base, step, inv, sum, to, reads);
    chk(result_o == 27'(sum * 1000 / 80), "R8 R3 R4 scaled result", result_o, sum * 1000 / 80);
    chk(timeout_o == to, "R7 timeout flag vs model", timeout_o, to);
    chk(int'(to) == exp_to, "R6 table timeout expectation", to, exp_to);
    chk(n_rd == reads, "R5 R6 read count", n_rd, reads);
    chk(n_wr == 1 && bad_order == 0 && bad_wr == 0, "R1 single mode write first",
        n_wr * 100 + bad_order * 10 + bad_wr, 100);
    chk(bad_addr == 0, "R2 read address", bad_addr, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done single cycle", done_o, 0);
  endtask

  initial begin
    #3600000;
    n_err++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [26:0] held;
    rst_n = 0; start_i = 0; mode_word_i = '0;
    cur_base = 0; cur_step = 0; cur_inv = 0; cur_stall = 0; cur_mode = 0;
    k = 0; n_wr = 0; n_rd = 0; bad_order = 0; bad_wr = 0; bad_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!req_valid_o && !rsp_ready_o, "R11 idle after reset", {req_valid_o, rsp_ready_o}, 0);
    chk(!done_o && !timeout_o, "R11 flags after reset", {done_o, timeout_o}, 0);
    chk(result_o == '0, "R11 result after reset", result_o, 0);

    for (int i = 0; i < NV; i++)
      run_measure(V_BASE[i], V_STEP[i], V_INV[i], V_STALL[i], V_MODE[i], V_TO[i], 0);

    // R7: the flag of the last timed-out run persists, result holds.
    held = result_o;
    repeat (5) @(negedge clk);
    chk(timeout_o == 1'b1, "R7 timeout sticky after done", timeout_o, 1);
    chk(result_o == held, "R8 result holds between runs", result_o, held);

    // R1: a second start in the middle of a run is ignored.
    run_measure(7, 3, 0, 1, 16'h3C3C, 0, 40);

    // R11: reset in the middle of a measurement.
    cur_base = 0; cur_step = 1; cur_inv = 0; cur_stall = 0; cur_mode = 16'h0055;
    k = 0; n_wr = 0; n_rd = 0;
    @(negedge clk);
    start_i = 1; mode_word_i = 16'h0055;
    @(negedge clk);
    start_i = 0;
    repeat (60) @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk(!req_valid_o && !rsp_ready_o && !done_o && !timeout_o, "R11 mid-run reset idle",
        {req_valid_o, rsp_ready_o, done_o, timeout_o}, 0);
    chk(result_o == '0, "R11 mid-run reset result", result_o, 0);
    rst_n = 1;
    run_measure(1023, 0, 0, 0, 16'h0013, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule